// File: doc/BRIEF.md
# Interrupt Line State Controller

This block tracks the state of up to 32 external interrupt lines. Each line has three separate state bits: enable, pending and active. Software changes enable and pending through paired set and clear registers on a simple synchronous bus. In each register a written 1 acts on its bit and a written 0 does nothing. The input lines are sampled in the block's clock domain. A rising edge on a sampled line marks that line pending, so a pulse of one clock and a held level are both caught.

The block offers the core one request at a time. The request is the lowest-numbered line that is pending, enabled and not active, and it is offered only while no line is active. The core accepts the request with an activation strobe. It ends the handler with a return strobe, which clears the active state. At that return, a line whose input is still high becomes pending again. Priority levels, preemption and vector handling belong to other blocks.

Top module: `irq_state_ctrl`

## Requirements
- R1: A write of 1 to a bit at offset 0x00 enables that line, and a written 0 has no effect. A read at offset 0x00 or 0x04 returns the enable state, with line n in data bit n.
- R2: A write of 1 to a bit at offset 0x04 disables that line, and a written 0 has no effect.
- R3: A write of 1 to a bit at offset 0x08 sets that line pending. A write of 1 at offset 0x0C clears it. A read at 0x08 or 0x0C returns the pending state.
- R4: An input that goes high at a clock edge makes its line pending two rising edges later, and a high of one clock is enough. This also happens on a disabled line, but a disabled line is never requested or made active.
- R5: `req_valid` is high only when no line is active. `req_id` then gives the lowest-numbered line that is pending, enabled and not active, and at most one line is ever active.
- R6: `take_i` while `req_valid` is high clears the pending bit of line `req_id` and sets its active bit at the same edge. `take_i` while `req_valid` is low has no effect.
- R7: `eret_i` clears the active state. A line whose sampled input is still high at that edge becomes pending again.
- R8: Disabling an active line leaves it active. Clearing the pending bit of an active line leaves it active.
- R9: A rising edge on the input of an active line sets its pending bit again.
- R10: Lines listed in `EN_TIE_LO` always read as disabled, and lines in `EN_TIE_HI` always read as enabled, from reset onward. Writes to those bits are ignored.
- R11: Offset 0x10 returns the active state and ignores writes. Offset 0x14 returns `NUM_LINES`.
- R12: After reset no line is pending or active, only the tied-high lines are enabled, and `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_LINES | Interrupt source lines |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, 0 when not reading |
| req_valid | output | 1 | A request is offered |
| req_id | output | ID_W | Number of the requested line |
| take_i | input | 1 | Core accepts the offered request |
| eret_i | input | 1 | Core returns from the active handler |

## Verification
Some rules can be checked on every cycle, and the assertions cover these. At most one line is active. A request is offered only while nothing is active, and only for a line that is pending and enabled. An accepted request becomes active, and a return clears the active state. Outside those two strobes the active state never changes, and no line turns active unless it was enabled. The tied enable bits keep their fixed values. Other behaviour needs a test scenario and is left to the bench. This covers the set and clear write semantics, the choice of the lowest-numbered line, the two-edge latency from the input, the capture of single-cycle pulses, a level line pending again after a return, and writes to the active register being ignored.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam logic [7:0] OFS_EN_SET = 8'h00;
  localparam logic [7:0] OFS_EN_CLR = 8'h04;
  localparam logic [7:0] OFS_PD_SET = 8'h08;
  localparam logic [7:0] OFS_PD_CLR = 8'h0C;
  localparam logic [7:0] OFS_ACT    = 8'h10;
  localparam logic [7:0] OFS_TYPE   = 8'h14;

  typedef struct packed {
    logic en_set;
    logic en_clr;
    logic pd_set;
    logic pd_clr;
  } wr_strobe_t;
endpackage

// File: rtl/irqc_sampler.sv
module irqc_sampler #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] smp_q, prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      prv_q <= '0;
    end else begin
      smp_q <= irq_i;
      prv_q <= smp_q;
    end
  end

  assign lvl_o  = smp_q;
  assign rise_o = smp_q & ~prv_q;
endmodule

// File: rtl/irqc_bus_if.sv
module irqc_bus_if
  import irqc_pkg::*;
#(
  parameter int N      = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N-1:0]      en_q,
  input  logic [N-1:0]      pend_q,
  input  logic [N-1:0]      act_q,
  output wr_strobe_t        stb_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [7:0] ofs;
  logic       wr_en, rd_en;

  assign ofs   = 8'(bus_addr);
  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  always_comb begin
    stb_o.en_set = wr_en && (ofs == OFS_EN_SET);
    stb_o.en_clr = wr_en && (ofs == OFS_EN_CLR);
    stb_o.pd_set = wr_en && (ofs == OFS_PD_SET);
    stb_o.pd_clr = wr_en && (ofs == OFS_PD_CLR);
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      case (ofs)
        OFS_EN_SET, OFS_EN_CLR: rdata_o[N-1:0] = en_q;
        OFS_PD_SET, OFS_PD_CLR: rdata_o[N-1:0] = pend_q;
        OFS_ACT:                rdata_o[N-1:0] = act_q;
        OFS_TYPE:               rdata_o        = DATA_W'(N);
        default:                rdata_o        = '0;
      endcase
    end
  end
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input  logic [N-1:0]  pend_q,
  input  logic [N-1:0]  en_q,
  input  logic [N-1:0]  act_q,
  output logic          valid_o,
  output logic [IW-1:0] id_o
);
  logic [N-1:0] cand;

  assign cand = pend_q & en_q & ~act_q;

  always_comb begin
    id_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) id_o = IW'(i);
    end
  end

  assign valid_o = (|cand) & ~(|act_q);
endmodule

// File: rtl/irq_state_ctrl.sv
module irq_state_ctrl
  import irqc_pkg::*;
#(
  parameter int                  NUM_LINES = 32,
  parameter int                  ADDR_W    = 8,
  parameter int                  DATA_W    = 32,
  parameter logic [NUM_LINES-1:0] EN_TIE_LO = '0,
  parameter logic [NUM_LINES-1:0] EN_TIE_HI = '0,
  localparam int                 ID_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 req_valid,
  output logic [ID_W-1:0]      req_id,
  input  logic                 take_i,
  input  logic                 eret_i
);
  localparam logic [NUM_LINES-1:0] EN_RST = EN_TIE_HI & ~EN_TIE_LO;

  logic [NUM_LINES-1:0] en_q, en_d;
  logic [NUM_LINES-1:0] pend_q, pend_d;
  logic [NUM_LINES-1:0] act_q, act_d;
  logic [NUM_LINES-1:0] lvl, rise, wmask, sel_oh;
  logic                 take_ok, en_ld, act_ld;
  wr_strobe_t           stb;

  irqc_sampler #(.N(NUM_LINES)) u_smp (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_i  (irq_i),
    .lvl_o  (lvl),
    .rise_o (rise)
  );

  irqc_bus_if #(.N(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .en_q     (en_q),
    .pend_q   (pend_q),
    .act_q    (act_q),
    .stb_o    (stb),
    .rdata_o  (bus_rdata)
  );

  irqc_pick #(.N(NUM_LINES), .IW(ID_W)) u_pick (
    .pend_q  (pend_q),
    .en_q    (en_q),
    .act_q   (act_q),
    .valid_o (req_valid),
    .id_o    (req_id)
  );

  assign wmask   = bus_wdata[NUM_LINES-1:0];
  assign take_ok = take_i & req_valid;
  assign sel_oh  = take_ok ? (NUM_LINES'(1) << req_id) : '0;
  assign en_ld   = stb.en_set | stb.en_clr;
  assign act_ld  = take_ok | eret_i;

  // Enable next state: set, then clear, then the tied bits override.
  always_comb begin
    en_d = en_q;
    if (stb.en_set) en_d = en_d | wmask;
    if (stb.en_clr) en_d = en_d & ~wmask;
    en_d = (en_d & ~EN_TIE_LO) | EN_TIE_HI;
  end

  // Pending next state: the clear sources go first and the set sources win.
  always_comb begin
    pend_d = pend_q;
    if (stb.pd_clr) pend_d = pend_d & ~wmask;
    pend_d = pend_d & ~sel_oh;
    if (stb.pd_set) pend_d = pend_d | wmask;
    pend_d = pend_d | rise;
    if (eret_i) pend_d = pend_d | (act_q & lvl);
  end

  // Active next state: a return clears it and an accepted request sets it.
  always_comb begin
    act_d = act_q;
    if (eret_i) act_d = '0;
    act_d = act_d | sel_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= EN_RST;
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (en_ld)  en_q  <= en_d;
      pend_q <= pend_d;
      if (act_ld) act_q <= act_d;
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int         N      = 32,
  parameter int         IW     = 5,
  parameter logic [N-1:0] TIE_LO = '0,
  parameter logic [N-1:0] TIE_HI = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          take_i,
  input logic          eret_i,
  input logic          req_valid,
  input logic [IW-1:0] req_id,
  input logic [N-1:0]  en_q,
  input logic [N-1:0]  pend_q,
  input logic [N-1:0]  act_q
);
  // R5
  one_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act_q) <= 1);

  // R5
  req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (act_q == '0) && pend_q[req_id] && en_q[req_id]);

  // R6
  take_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && req_valid) |=> act_q[$past(req_id)]);

  // R7
  eret_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && !(take_i && req_valid)) |=> (act_q == '0));

  // R8
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i && !eret_i) |=> $stable(act_q));

  // R4
  no_disabled_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && req_valid) |-> en_q[req_id]);

  // R10
  tie_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q & TIE_LO) == '0) && ((en_q & TIE_HI) == TIE_HI));
endmodule

bind irq_state_ctrl irqc_chk #(
  .N(NUM_LINES), .IW(ID_W), .TIE_LO(EN_TIE_LO), .TIE_HI(EN_TIE_HI)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .take_i    (take_i),
  .eret_i    (eret_i),
  .req_valid (req_valid),
  .req_id    (req_id),
  .en_q      (en_q),
  .pend_q    (pend_q),
  .act_q     (act_q)
);

// File: tb/tb_irq_state_ctrl.sv
`timescale 1ns/100ps
module tb_irq_state_ctrl;
  localparam int          N    = 32;
  localparam logic [31:0] TLO  = 32'h8000_0000;
  localparam logic [31:0] THI  = 32'h4000_0000;
  localparam int          NVEC = 6;
  // {offset, write data, expected enable state}
  localparam logic [71:0] VEC [NVEC] = '{
    {8'h00, 32'h0000_00FF, 32'h4000_00FF},
    {8'h00, 32'h0000_0000, 32'h4000_00FF},
    {8'h04, 32'h0000_000F, 32'h4000_00F0},
    {8'h04, 32'h0000_0000, 32'h4000_00F0},
    {8'h00, 32'hFFFF_FFFF, 32'h7FFF_FFFF},
    {8'h04, 32'hFFFF_FFFF, 32'h4000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [N-1:0] irq;
  logic        bus_sel, bus_wr, take, eret;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, rv;
  logic        req_valid;
  logic [4:0]  req_id;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  irq_state_ctrl #(.NUM_LINES(N), .EN_TIE_LO(TLO), .EN_TIE_HI(THI)) dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_valid(req_valid), .req_id(req_id), .take_i(take), .eret_i(eret)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #0.5;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic strobe(input bit is_take);
    if (is_take) take = 1'b1; else eret = 1'b1;
    @(negedge clk);
    take = 1'b0; eret = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq = '0; bus_sel = 0; bus_wr = 0; bus_addr = '0;
    bus_wdata = '0; take = 0; eret = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state, R10 tied reset value
    rd(8'h00, rv); chk("R12 R10 enable after reset", rv, THI);
    rd(8'h08, rv); chk("R12 pending after reset", rv, 0);
    rd(8'h10, rv); chk("R12 active after reset", rv, 0);
    chk("R12 req_valid after reset", 32'(req_valid), 0);
    // R11 type register
    rd(8'h14, rv); chk("R11 type register", rv, 32);

    // R1 R2 R10 vector walk: read both offsets after each write
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(8'h00, rv); chk($sformatf("R1 R2 R10 vec%0d set view", i), rv, VEC[i][31:0]);
      rd(8'h04, rv); chk($sformatf("R1 vec%0d clear view", i), rv, VEC[i][31:0]);
    end

    // R3 pending via the bus; R4 disabled lines are not requested
    wr(8'h08, 32'h0000_0110);
    rd(8'h08, rv); chk("R3 set pending", rv, 32'h110);
    rd(8'h0C, rv); chk("R3 pending on clear view", rv, 32'h110);
    chk("R4 disabled pending no request", 32'(req_valid), 0);
    wr(8'h0C, 32'h0000_0100);
    rd(8'h08, rv); chk("R3 clear pending", rv, 32'h10);
    wr(8'h00, 32'h0000_0010);
    chk("R5 single request valid", 32'(req_valid), 1);
    chk("R5 single request id", 32'(req_id), 4);
    wr(8'h08, 32'h0000_0004);
    wr(8'h00, 32'h0000_0004);
    chk("R5 lowest line wins", 32'(req_id), 2);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h04, 32'h0000_0014);
    chk("R3 all cleared no request", 32'(req_valid), 0);

    // R4 one-clock pulse on a disabled line
    irq[9] = 1'b1; @(negedge clk); irq[9] = 1'b0; @(negedge clk);
    rd(8'h08, rv); chk("R4 pulse latched on disabled line", rv, 32'h200);
    chk("R4 disabled line not requested", 32'(req_valid), 0);
    wr(8'h0C, 32'h0000_0200);

    // R6 take when nothing is offered is ignored
    strobe(1'b1);
    rd(8'h10, rv); chk("R6 take without request ignored", rv, 0);

    // Level source on line 3
    wr(8'h00, 32'h0000_0008);
    irq[3] = 1'b1;
    @(negedge clk);
    rd(8'h08, rv); chk("R4 not yet pending after one edge", rv, 0);
    @(negedge clk);
    rd(8'h08, rv); chk("R4 pending after two edges", rv, 32'h8);
    chk("R5 request line 3", 32'(req_id), 3);
    strobe(1'b1);
    rd(8'h10, rv); chk("R6 take sets active", rv, 32'h8);
    rd(8'h08, rv); chk("R6 take clears pending", rv, 0);
    chk("R5 no request while active", 32'(req_valid), 0);

    // R8 clear-pending and disable do not touch active
    wr(8'h0C, 32'h0000_0008);
    rd(8'h10, rv); chk("R8 clear pending keeps active", rv, 32'h8);
    wr(8'h04, 32'h0000_0008);
    rd(8'h10, rv); chk("R8 disable keeps active", rv, 32'h8);
    // R11 writes to active ignored
    wr(8'h10, 32'h0000_00FF);
    rd(8'h10, rv); chk("R11 active write ignored", rv, 32'h8);
    wr(8'h00, 32'h0000_0008);

    // R9 pulse re-pends while active
    irq[3] = 1'b0; @(negedge clk); @(negedge clk);
    irq[3] = 1'b1; @(negedge clk); irq[3] = 1'b0; @(negedge clk);
    rd(8'h08, rv); chk("R9 re-pend while active", rv, 32'h8);
    rd(8'h10, rv); chk("R9 still active", rv, 32'h8);
    wr(8'h0C, 32'h0000_0008);

    // R7 level still high at return re-pends
    irq[3] = 1'b1; @(negedge clk); @(negedge clk);
    wr(8'h0C, 32'h0000_0008);
    rd(8'h08, rv); chk("R7 pending cleared before return", rv, 0);
    wr(8'h08, 32'h0000_0002);
    wr(8'h00, 32'h0000_0002);
    chk("R5 blocked while active", 32'(req_valid), 0);
    strobe(1'b0);
    rd(8'h10, rv); chk("R7 return clears active", rv, 0);
    rd(8'h08, rv); chk("R7 level re-pends on return", rv, 32'h0A);
    chk("R5 lowest after return valid", 32'(req_valid), 1);
    chk("R5 lowest after return id", 32'(req_id), 1);

    // R7 return with input low: no re-pend
    irq[3] = 1'b0;
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h08, 32'h0000_0008);
    @(negedge clk);
    strobe(1'b1);
    strobe(1'b0);
    rd(8'h08, rv); chk("R7 low input no re-pend", rv, 0);
    rd(8'h10, rv); chk("R7 active cleared", rv, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule